// File: doc/BRIEF.md
# TDM Timeslot Playout Engine

This block drives buffered channel bytes onto a frame-based serial TDM bus. A frame is a fixed number of timeslots and each timeslot is eight bit periods long. A programmable association table says, for every timeslot, whether the slot is in use. For a slot in use, the table also gives the channel that feeds it, whether that channel carries voice or HDLC traffic, and how a voice channel fills a gap. At the start of each slot the block looks up the entry and reads one byte from that channel's circular playout buffer. It then shifts the byte out MSB first.

The packet side fills the buffers through a write port and reports one write pointer per channel. The playout side publishes its read pointers back, and these pointers are the only contact between the two sides. The playout side runs on frame timing alone. When a channel's buffer is empty, stale bytes are never replayed. A voice channel instead sends, as configured for it, a byte from a small per-channel tone pattern, a silence octet, or a programmable padding octet. An HDLC channel sends a programmable idle code. Each insertion of fill sets a sticky per-channel underrun flag, and that flag is cleared by writing a one to it.

Top module: `tdm_playout`

## Requirements
- R1: `frame_pulse` is high for exactly the first bit period of timeslot 0 and low otherwise, so pulses are NUM_SLOTS*8 clocks apart.
- R2: Each timeslot lasts eight clocks. Its byte is driven on `tdm_out` MSB first, and `tdm_oe` holds one value for the whole slot.
- R3: For a valid slot whose channel buffer holds data (read pointer differs from the write pointer), the byte at the read pointer is sent with `tdm_oe` high. The read pointer then advances by one modulo BUF_DEPTH.
- R4: A slot whose association entry has valid=0 keeps `tdm_oe` low for all eight bits and consumes no buffer byte.
- R5: An empty voice slot with fill mode 2'b00 sends entry k of that channel's tone table, where k is the frame number since reset modulo TONE_LEN.
- R6: An empty voice slot with fill mode 2'b01 sends 0xFF.
- R7: An empty voice slot with fill mode 2'b10 or 2'b11 sends the programmed padding octet.
- R8: An empty HDLC slot (type bit 1) sends the idle code. The idle code is 0x7E after reset and can be reprogrammed.
- R9: Fill insertion leaves the read pointer unchanged, so bytes written later are played out in order.
- R10: `uflag[c]` is set whenever fill is sent for channel c and stays set until a one is written to `uflag_clr[c]`. A set in the same cycle as a clear wins.
- R11: During reset `tdm_oe`, `frame_pulse` and every `uflag` bit are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial bit per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| assoc_we | input | 1 | Write strobe for the association table |
| assoc_slot | input | SLOT_W | Timeslot to write |
| assoc_valid | input | 1 | Slot in use |
| assoc_hdlc | input | 1 | 1 = HDLC channel, 0 = voice channel |
| assoc_ch | input | CH_W | Channel feeding the slot |
| assoc_fill | input | 2 | Voice fill: 00 tone, 01 silence, 10/11 padding |
| buf_we | input | 1 | Playout buffer write strobe (packet side) |
| buf_ch | input | CH_W | Channel of the buffer write |
| buf_addr | input | PTR_W | Buffer location written |
| buf_data | input | 8 | Byte written |
| wr_ptr_flat | input | NUM_CH*PTR_W | Write pointer per channel, channel c at bits [c*PTR_W +: PTR_W] |
| rd_ptr_flat | output | NUM_CH*PTR_W | Read pointer per channel, same packing |
| tone_we | input | 1 | Tone table write strobe |
| tone_ch | input | CH_W | Channel of the tone write |
| tone_idx | input | TI_W | Pattern entry written |
| tone_data | input | 8 | Pattern byte |
| cfg_we | input | 1 | Loads padding octet and idle code |
| cfg_pad | input | 8 | Padding octet |
| cfg_idle | input | 8 | HDLC idle code |
| uflag_clr | input | NUM_CH | Write-one-to-clear for the underrun flags |
| uflag | output | NUM_CH | Sticky underrun flag per channel |
| tdm_out | output | 1 | Serial data, MSB first |
| tdm_oe | output | 1 | Output enable; low means the slot is not driven |
| frame_pulse | output | 1 | Marks the first bit of timeslot 0 |

## Verification
The assertions assume the packet side never lets a write pointer lap the read pointer, so at most BUF_DEPTH-1 bytes are unread. They also assume a buffer byte is written at least one clock before the write pointer moves past it, and that channel counts and buffer depths are powers of two. The bench never holds more than BUF_DEPTH-1 unread bytes in a channel. Each push writes the byte in one clock and advances the pointer in the next. The bench also applies its model's view of every write only after the clock edge at which the design sees it, so the model and the design agree even when a write meets a slot fetch.

// File: rtl/tdm_playout_pkg.sv
// Package: shared encodings for the TDM playout engine.
// Assumes: nothing beyond IEEE 1800-2017.
package tdm_playout_pkg;

    // Voice fill selection carried in each association entry.
    typedef enum logic [1:0] {
        FILL_TONE    = 2'b00,
        FILL_SILENCE = 2'b01,
        FILL_PAD     = 2'b10,
        FILL_PAD_ALT = 2'b11
    } fill_mode_e;

    localparam logic [7:0] SILENCE_OCTET = 8'hFF;
    localparam logic [7:0] IDLE_DEFAULT  = 8'h7E;
    localparam logic [7:0] PAD_DEFAULT   = 8'h00;
    localparam int         BITS_PER_SLOT = 8;

endpackage

// File: rtl/tdm_timebase.sv
// Module: tdm_timebase
// Counts bit periods and timeslots of the TDM frame. It raises load_o on
// the last bit of every slot so that the next slot's byte is fetched in time.
// Assumes: NUM_SLOTS >= 2. Reset parks the counters on the last bit of the
// last slot, so the first edge after reset loads slot 0.
module tdm_timebase #(
    parameter int NUM_SLOTS = 8,
    localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [SLOT_W-1:0] slot_o,
    output logic [2:0]        bit_o,
    output logic              load_o,
    output logic [SLOT_W-1:0] next_slot_o
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

    logic [SLOT_W-1:0] slot_q;
    logic [2:0]        bit_q;

    // Advance the bit counter each clock and the slot counter on bit 7.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= LAST_SLOT;
            bit_q  <= 3'd7;
        end else begin
            bit_q <= bit_q + 3'd1;
            if (bit_q == 3'd7) begin
                slot_q <= next_slot_o;
            end
        end
    end

    // Derive the fetch strobe and the slot about to start.
    always_comb begin
        load_o      = (bit_q == 3'd7);
        next_slot_o = (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
    end

    assign slot_o = slot_q;
    assign bit_o  = bit_q;

    p_slot_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_q != 3'd7) |=> (slot_q == $past(slot_q)));
    p_slot_steps_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_q == 3'd7 && slot_q == LAST_SLOT) |=> (slot_q == '0 && bit_q == 3'd0));

endmodule

// File: rtl/tdm_assoc_mem.sv
// Module: tdm_assoc_mem
// Timeslot association table. Each entry holds a valid bit, a channel type,
// a channel index and a voice fill mode. It has one write port and one
// combinational read port.
// Assumes: a write and a read of the same entry in one cycle return the old entry.
module tdm_assoc_mem #(
    parameter int NUM_SLOTS = 8,
    parameter int NUM_CH    = 4,
    localparam int SLOT_W = $clog2(NUM_SLOTS),
    localparam int CH_W   = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [SLOT_W-1:0] wslot_i,
    input  logic              wvalid_i,
    input  logic              whdlc_i,
    input  logic [CH_W-1:0]   wch_i,
    input  logic [1:0]        wfill_i,
    input  logic [SLOT_W-1:0] rslot_i,
    output logic              valid_o,
    output logic              hdlc_o,
    output logic [CH_W-1:0]   ch_o,
    output logic [1:0]        fill_o
);
    logic              valid_q [NUM_SLOTS];
    logic              hdlc_q  [NUM_SLOTS];
    logic [CH_W-1:0]   ch_q    [NUM_SLOTS];
    logic [1:0]        fill_q  [NUM_SLOTS];

    // Clear every entry on reset, then accept single-entry writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SLOTS; s++) begin
                valid_q[s] <= 1'b0;
                hdlc_q[s]  <= 1'b0;
                ch_q[s]    <= '0;
                fill_q[s]  <= '0;
            end
        end else if (we_i) begin
            valid_q[wslot_i] <= wvalid_i;
            hdlc_q[wslot_i]  <= whdlc_i;
            ch_q[wslot_i]    <= wch_i;
            fill_q[wslot_i]  <= wfill_i;
        end
    end

    // Present the entry of the slot being fetched.
    always_comb begin
        valid_o = valid_q[rslot_i];
        hdlc_o  = hdlc_q[rslot_i];
        ch_o    = ch_q[rslot_i];
        fill_o  = fill_q[rslot_i];
    end

endmodule

// File: rtl/tdm_chan_state.sv
// Module: tdm_chan_state
// Per-channel playout state: the circular buffer RAM, the read pointers, the
// tone pattern table, the frame-driven tone index and the sticky underrun flags.
// On a fetch it consumes a byte when the buffer is non-empty and otherwise
// records an underrun.
// Assumes: NUM_CH, BUF_DEPTH and TONE_LEN are powers of two. The write side
// never holds more than BUF_DEPTH-1 unread bytes.
module tdm_chan_state #(
    parameter int NUM_CH    = 4,
    parameter int BUF_DEPTH = 8,
    parameter int TONE_LEN  = 4,
    localparam int CH_W  = $clog2(NUM_CH),
    localparam int PTR_W = $clog2(BUF_DEPTH),
    localparam int TI_W  = $clog2(TONE_LEN)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_i,
    input  logic                    last_slot_i,
    input  logic                    valid_i,
    input  logic [CH_W-1:0]         ch_i,
    input  logic [NUM_CH*PTR_W-1:0] wr_ptr_flat_i,
    input  logic                    buf_we_i,
    input  logic [CH_W-1:0]         buf_ch_i,
    input  logic [PTR_W-1:0]        buf_addr_i,
    input  logic [7:0]              buf_data_i,
    input  logic                    tone_we_i,
    input  logic [CH_W-1:0]         tone_ch_i,
    input  logic [TI_W-1:0]         tone_idx_i,
    input  logic [7:0]              tone_data_i,
    input  logic [NUM_CH-1:0]       uflag_clr_i,
    output logic                    empty_o,
    output logic [7:0]              data_o,
    output logic [7:0]              tone_o,
    output logic [NUM_CH*PTR_W-1:0] rd_ptr_flat_o,
    output logic [NUM_CH-1:0]       uflag_o
);
    logic [7:0]       buf_mem  [NUM_CH][BUF_DEPTH];
    logic [7:0]       tone_mem [NUM_CH][TONE_LEN];
    logic [PTR_W-1:0] rd_ptr_q [NUM_CH];
    logic [PTR_W-1:0] wr_ptr   [NUM_CH];
    logic [TI_W-1:0]  tone_idx_q;
    logic [NUM_CH-1:0] uflag_q;
    logic             consume;
    logic             fill;

    // Unpack the write pointers and pack the read pointers per channel.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ptr
        assign wr_ptr[c] = wr_ptr_flat_i[c*PTR_W +: PTR_W];
        assign rd_ptr_flat_o[c*PTR_W +: PTR_W] = rd_ptr_q[c];
    end

    // Buffer RAM write port driven by the packet side.
    always_ff @(posedge clk) begin
        if (buf_we_i) begin
            buf_mem[buf_ch_i][buf_addr_i] <= buf_data_i;
        end
    end

    // Tone pattern table write port.
    always_ff @(posedge clk) begin
        if (tone_we_i) begin
            tone_mem[tone_ch_i][tone_idx_i] <= tone_data_i;
        end
    end

    // Look up emptiness, the next byte and the current tone byte.
    always_comb begin
        empty_o = (rd_ptr_q[ch_i] == wr_ptr[ch_i]);
        data_o  = buf_mem[ch_i][rd_ptr_q[ch_i]];
        tone_o  = tone_mem[ch_i][tone_idx_q];
        consume = load_i && valid_i && !empty_o;
        fill    = load_i && valid_i && empty_o;
    end

    // Advance the read pointer of the fetched channel when a byte is consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CH; c++) begin
                rd_ptr_q[c] <= '0;
            end
        end else if (consume) begin
            rd_ptr_q[ch_i] <= rd_ptr_q[ch_i] + 1'b1;
        end
    end

    // Step the tone pattern index once per frame, after the last slot's fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tone_idx_q <= '0;
        end else if (load_i && last_slot_i) begin
            tone_idx_q <= (tone_idx_q == TI_W'(TONE_LEN - 1)) ? '0 : tone_idx_q + 1'b1;
        end
    end

    // Sticky underrun flags: clear on write-one, set on fill (set wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uflag_q <= '0;
        end else begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (fill && ch_i == CH_W'(c)) begin
                    uflag_q[c] <= 1'b1;
                end else if (uflag_clr_i[c]) begin
                    uflag_q[c] <= 1'b0;
                end
            end
        end
    end

    assign uflag_o = uflag_q;

    p_rdptr_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
        consume |=> (rd_ptr_q[$past(ch_i)] == PTR_W'($past(rd_ptr_q[ch_i]) + 1'b1)));
    p_fill_holds_ptr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fill |=> (rd_ptr_q[$past(ch_i)] == $past(rd_ptr_q[ch_i])));
    p_uflag_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fill |=> uflag_q[$past(ch_i)]);

endmodule

// File: rtl/tdm_fill_sel.sv
// Module: tdm_fill_sel
// Chooses the byte for a timeslot: buffered data when present, otherwise the
// fill the channel type and fill mode call for. An unused slot is not driven.
// Assumes: all inputs are stable combinational lookups for one slot.
module tdm_fill_sel
    import tdm_playout_pkg::*;
(
    input  logic       valid_i,
    input  logic       hdlc_i,
    input  logic [1:0] fill_i,
    input  logic       empty_i,
    input  logic [7:0] data_i,
    input  logic [7:0] tone_i,
    input  logic [7:0] pad_i,
    input  logic [7:0] idle_i,
    output logic [7:0] byte_o,
    output logic       oe_o
);
    // Select data, tone, silence, padding or idle code for the slot.
    always_comb begin
        oe_o   = valid_i;
        byte_o = '0;
        if (valid_i) begin
            if (!empty_i) begin
                byte_o = data_i;
            end else if (hdlc_i) begin
                byte_o = idle_i;
            end else begin
                case (fill_mode_e'(fill_i))
                    FILL_TONE:    byte_o = tone_i;
                    FILL_SILENCE: byte_o = SILENCE_OCTET;
                    default:      byte_o = pad_i;
                endcase
            end
        end
    end

endmodule

// File: rtl/tdm_playout.sv
// Module: tdm_playout (top)
// TDM playout engine. On the last bit of each slot it fetches the next slot's
// association entry, selects buffered data or fill, and loads the byte into an
// MSB-first shift register. Output enable and frame pulse are registered with it.
// Assumes: power-of-two NUM_CH, BUF_DEPTH and TONE_LEN. The packet side keeps
// its write pointers within BUF_DEPTH-1 of the read pointers.
module tdm_playout
    import tdm_playout_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int NUM_CH    = 4,
    parameter int BUF_DEPTH = 8,
    parameter int TONE_LEN  = 4,
    localparam int SLOT_W = $clog2(NUM_SLOTS),
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int PTR_W  = $clog2(BUF_DEPTH),
    localparam int TI_W   = $clog2(TONE_LEN)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    assoc_we,
    input  logic [SLOT_W-1:0]       assoc_slot,
    input  logic                    assoc_valid,
    input  logic                    assoc_hdlc,
    input  logic [CH_W-1:0]         assoc_ch,
    input  logic [1:0]              assoc_fill,
    input  logic                    buf_we,
    input  logic [CH_W-1:0]         buf_ch,
    input  logic [PTR_W-1:0]        buf_addr,
    input  logic [7:0]              buf_data,
    input  logic [NUM_CH*PTR_W-1:0] wr_ptr_flat,
    output logic [NUM_CH*PTR_W-1:0] rd_ptr_flat,
    input  logic                    tone_we,
    input  logic [CH_W-1:0]         tone_ch,
    input  logic [TI_W-1:0]         tone_idx,
    input  logic [7:0]              tone_data,
    input  logic                    cfg_we,
    input  logic [7:0]              cfg_pad,
    input  logic [7:0]              cfg_idle,
    input  logic [NUM_CH-1:0]       uflag_clr,
    output logic [NUM_CH-1:0]       uflag,
    output logic                    tdm_out,
    output logic                    tdm_oe,
    output logic                    frame_pulse
);
    logic [SLOT_W-1:0] slot, next_slot;
    logic [2:0]        bit_cnt;
    logic              load;
    logic              a_valid, a_hdlc;
    logic [CH_W-1:0]   a_ch;
    logic [1:0]        a_fill;
    logic              empty;
    logic [7:0]        data_byte, tone_byte, sel_byte;
    logic              sel_oe;
    logic [7:0]        pad_q, idle_q, shreg_q;
    logic              oe_q, fp_q;

    tdm_timebase #(.NUM_SLOTS(NUM_SLOTS)) u_tb (
        .clk(clk), .rst_n(rst_n), .slot_o(slot), .bit_o(bit_cnt),
        .load_o(load), .next_slot_o(next_slot)
    );

    tdm_assoc_mem #(.NUM_SLOTS(NUM_SLOTS), .NUM_CH(NUM_CH)) u_assoc (
        .clk(clk), .rst_n(rst_n), .we_i(assoc_we), .wslot_i(assoc_slot),
        .wvalid_i(assoc_valid), .whdlc_i(assoc_hdlc), .wch_i(assoc_ch),
        .wfill_i(assoc_fill), .rslot_i(next_slot), .valid_o(a_valid),
        .hdlc_o(a_hdlc), .ch_o(a_ch), .fill_o(a_fill)
    );

    tdm_chan_state #(.NUM_CH(NUM_CH), .BUF_DEPTH(BUF_DEPTH), .TONE_LEN(TONE_LEN)) u_chan (
        .clk(clk), .rst_n(rst_n), .load_i(load),
        .last_slot_i(next_slot == SLOT_W'(NUM_SLOTS - 1)),
        .valid_i(a_valid), .ch_i(a_ch), .wr_ptr_flat_i(wr_ptr_flat),
        .buf_we_i(buf_we), .buf_ch_i(buf_ch), .buf_addr_i(buf_addr),
        .buf_data_i(buf_data), .tone_we_i(tone_we), .tone_ch_i(tone_ch),
        .tone_idx_i(tone_idx), .tone_data_i(tone_data), .uflag_clr_i(uflag_clr),
        .empty_o(empty), .data_o(data_byte), .tone_o(tone_byte),
        .rd_ptr_flat_o(rd_ptr_flat), .uflag_o(uflag)
    );

    tdm_fill_sel u_sel (
        .valid_i(a_valid), .hdlc_i(a_hdlc), .fill_i(a_fill), .empty_i(empty),
        .data_i(data_byte), .tone_i(tone_byte), .pad_i(pad_q), .idle_i(idle_q),
        .byte_o(sel_byte), .oe_o(sel_oe)
    );

    // Padding octet and idle code configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pad_q  <= PAD_DEFAULT;
            idle_q <= IDLE_DEFAULT;
        end else if (cfg_we) begin
            pad_q  <= cfg_pad;
            idle_q <= cfg_idle;
        end
    end

    // Serializer: load a new byte per slot, shift MSB first otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            oe_q    <= 1'b0;
            fp_q    <= 1'b0;
        end else if (load) begin
            shreg_q <= sel_byte;
            oe_q    <= sel_oe;
            fp_q    <= (next_slot == '0);
        end else begin
            shreg_q <= {shreg_q[6:0], 1'b0};
            fp_q    <= 1'b0;
        end
    end

    assign tdm_out     = shreg_q[7];
    assign tdm_oe      = oe_q;
    assign frame_pulse = fp_q;

    p_pulse_on_slot0_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |-> (slot == '0 && bit_cnt == 3'd0));
    p_unused_slot_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !a_valid) |=> !tdm_oe);
    p_oe_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(tdm_oe));

endmodule

// File: tb/tdm_playout_test.sv
`timescale 1ns/1ps
module tdm_playout_test;
    localparam int NS = 8, NC = 4, DEP = 8, TL = 4;
    localparam int FRAME = NS * 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic assoc_we = 0, assoc_valid = 0, assoc_hdlc = 0;
    logic [2:0] assoc_slot = 0;
    logic [1:0] assoc_ch = 0, assoc_fill = 0;
    logic buf_we = 0;
    logic [1:0] buf_ch = 0;
    logic [2:0] buf_addr = 0;
    logic [7:0] buf_data = 0;
    logic [2:0] wr_q [NC];
    logic [NC*3-1:0] wr_ptr_flat, rd_ptr_flat;
    logic tone_we = 0;
    logic [1:0] tone_ch = 0, tone_idx = 0;
    logic [7:0] tone_data = 0;
    logic cfg_we = 0;
    logic [7:0] cfg_pad = 0, cfg_idle = 0;
    logic [NC-1:0] uflag_clr = 0, uflag;
    logic tdm_out, tdm_oe, frame_pulse;

    for (genvar c = 0; c < NC; c++) begin : g_wr
        assign wr_ptr_flat[c*3 +: 3] = wr_q[c];
    end

    tdm_playout #(.NUM_SLOTS(NS), .NUM_CH(NC), .BUF_DEPTH(DEP), .TONE_LEN(TL)) uut (
        .clk(clk), .rst_n(rst_n), .assoc_we(assoc_we), .assoc_slot(assoc_slot),
        .assoc_valid(assoc_valid), .assoc_hdlc(assoc_hdlc), .assoc_ch(assoc_ch),
        .assoc_fill(assoc_fill), .buf_we(buf_we), .buf_ch(buf_ch),
        .buf_addr(buf_addr), .buf_data(buf_data), .wr_ptr_flat(wr_ptr_flat),
        .rd_ptr_flat(rd_ptr_flat), .tone_we(tone_we), .tone_ch(tone_ch),
        .tone_idx(tone_idx), .tone_data(tone_data), .cfg_we(cfg_we),
        .cfg_pad(cfg_pad), .cfg_idle(cfg_idle), .uflag_clr(uflag_clr),
        .uflag(uflag), .tdm_out(tdm_out), .tdm_oe(tdm_oe), .frame_pulse(frame_pulse)
    );

    always #2.5 clk = ~clk;

    int checks = 0, errors = 0;
    bit done = 0;

    // Bench model of the block's state
    int m_valid [NS], m_hdlc [NS], m_ch [NS], m_fill [NS];
    int m_rd [NC], m_wr [NC], m_flag [NC];
    int m_buf [NC][DEP];
    int m_tone [NC][TL];
    int m_pad = 0, m_idle = 8'h7E;
    int pos = -1, frame_no = 0;
    int exp_byte = 0, exp_oe = 0;
    string exp_req = "";
    logic [7:0] got = 0;

    // Pending model updates, applied after the edge at which the design sees them
    int pa_slot = -1, pa_v, pa_h, pa_c, pa_f;
    int pb_ch = -1, pb_a, pb_d;
    int pw_ch = -1, pw_v;
    int pt_ch = -1, pt_i, pt_d;
    int pcfg = 0, pcfg_pad, pcfg_idle;
    logic [NC-1:0] pclr = 0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, expv, $time);
        end
    endtask

    task automatic model_slot(input int s);
        int ch;
        exp_oe = m_valid[s];
        if (!m_valid[s]) begin
            exp_req = "R4";
            return;
        end
        ch = m_ch[s];
        if (m_rd[ch] != m_wr[ch]) begin
            exp_byte = m_buf[ch][m_rd[ch]];
            m_rd[ch] = (m_rd[ch] + 1) % DEP;
            exp_req = "R3 data R9";
        end else begin
            m_flag[ch] = 1;
            if (m_hdlc[s]) begin
                exp_byte = m_idle; exp_req = "R8 idle";
            end else if (m_fill[s] == 0) begin
                exp_byte = m_tone[ch][frame_no % TL]; exp_req = "R5 tone";
            end else if (m_fill[s] == 1) begin
                exp_byte = 8'hFF; exp_req = "R6 silence";
            end else begin
                exp_byte = m_pad; exp_req = "R7 padding";
            end
        end
    endtask

    // One clock: observe at the negedge, then retire pending model updates
    task automatic tick();
        int slot, bitn, flagv;
        @(negedge clk);
        for (int c = 0; c < NC; c++) if (pclr[c]) m_flag[c] = 0;
        if (pos < 0) begin
            if (frame_pulse) begin pos = 0; frame_no = 0; end
        end else begin
            pos = (pos + 1) % FRAME;
            if (pos == 0) frame_no++;
            chk(frame_pulse === (pos == 0), "R1 frame_pulse", int'(frame_pulse), int'(pos == 0));
        end
        if (pos >= 0) begin
            slot = pos / 8;
            bitn = pos % 8;
            if (bitn == 0) begin
                model_slot(slot);
                chk(tdm_oe === exp_oe[0], exp_oe ? "R3 oe" : "R4 oe", int'(tdm_oe), exp_oe);
                got = 0;
            end else begin
                chk(tdm_oe === exp_oe[0], "R2 oe steady", int'(tdm_oe), exp_oe);
            end
            got = {got[6:0], tdm_out};
            if (bitn == 4) begin
                flagv = 0;
                for (int c = 0; c < NC; c++) flagv |= (m_flag[c] << c);
                chk(uflag == flagv[NC-1:0], "R10 uflag", int'(uflag), flagv);
            end
            if (bitn == 7 && exp_oe != 0)
                chk(got == exp_byte[7:0], {exp_req, " R2 byte"}, int'(got), exp_byte);
        end
        if (pa_slot >= 0) begin
            m_valid[pa_slot] = pa_v; m_hdlc[pa_slot] = pa_h;
            m_ch[pa_slot] = pa_c; m_fill[pa_slot] = pa_f;
        end
        if (pb_ch >= 0) m_buf[pb_ch][pb_a] = pb_d;
        if (pw_ch >= 0) m_wr[pw_ch] = pw_v;
        if (pt_ch >= 0) m_tone[pt_ch][pt_i] = pt_d;
        if (pcfg != 0) begin m_pad = pcfg_pad; m_idle = pcfg_idle; end
        pa_slot = -1; pb_ch = -1; pw_ch = -1; pt_ch = -1; pcfg = 0; pclr = 0;
        assoc_we = 0; buf_we = 0; tone_we = 0; cfg_we = 0; uflag_clr = 0;
    endtask

    task automatic run(input int n);
        repeat (n) tick();
    endtask

    task automatic set_assoc(input int s, input int v, input int h, input int c, input int f);
        assoc_we = 1; assoc_slot = 3'(s); assoc_valid = v[0]; assoc_hdlc = h[0];
        assoc_ch = 2'(c); assoc_fill = 2'(f);
        pa_slot = s; pa_v = v; pa_h = h; pa_c = c; pa_f = f;
        tick();
    endtask

    task automatic push(input int c, input int b);
        int nw;
        buf_we = 1; buf_ch = 2'(c); buf_addr = 3'(m_wr[c]); buf_data = 8'(b);
        pb_ch = c; pb_a = m_wr[c]; pb_d = b;
        tick();
        nw = (m_wr[c] + 1) % DEP;
        wr_q[c] = 3'(nw);
        pw_ch = c; pw_v = nw;
        tick();
    endtask

    task automatic set_cfg(input int pad, input int idle);
        cfg_we = 1; cfg_pad = 8'(pad); cfg_idle = 8'(idle);
        pcfg = 1; pcfg_pad = pad; pcfg_idle = idle;
        tick();
    endtask

    task automatic clear_flags(input logic [NC-1:0] m);
        uflag_clr = m; pclr = m;
        tick();
    endtask

    initial begin
        for (int c = 0; c < NC; c++) begin
            wr_q[c] = 0; m_rd[c] = 0; m_wr[c] = 0; m_flag[c] = 0;
        end
        for (int s = 0; s < NS; s++) begin
            m_valid[s] = 0; m_hdlc[s] = 0; m_ch[s] = 0; m_fill[s] = 0;
        end
        // R11: reset state
        repeat (4) begin
            @(negedge clk);
            chk(tdm_oe === 1'b0, "R11 oe in reset", int'(tdm_oe), 0);
            chk(frame_pulse === 1'b0, "R11 pulse in reset", int'(frame_pulse), 0);
            chk(uflag === '0, "R11 uflag in reset", int'(uflag), 0);
        end
        rst_n = 1'b1;
        // R4: table empty after reset, nothing driven for a frame
        run(FRAME);
        // Tone patterns: channel c entry i = 0x10*c + 3*i + 1
        for (int c = 0; c < NC; c++)
            for (int i = 0; i < TL; i++) begin
                tone_we = 1; tone_ch = 2'(c); tone_idx = 2'(i);
                tone_data = 8'(16 * c + 3 * i + 1);
                pt_ch = c; pt_i = i; pt_d = 16 * c + 3 * i + 1;
                tick();
            end
        set_cfg(8'h5A, 8'h7E);
        set_assoc(1, 1, 0, 0, 0);   // voice tone
        set_assoc(2, 1, 0, 1, 1);   // voice silence
        set_assoc(4, 1, 0, 2, 2);   // voice padding
        set_assoc(5, 1, 1, 3, 0);   // HDLC
        set_assoc(3, 0, 0, 0, 0);   // R4: unused slot naming ch0
        // R5 R6 R7 R8: empty buffers across several frames
        run(4 * FRAME);
        // R3 R9: data after fill, then drain back to fill
        push(0, 8'hA1); push(0, 8'hA2); push(0, 8'hA3);
        push(1, 8'hB1); push(1, 8'hB2);
        for (int k = 0; k < 5; k++) push(2, 8'hC0 + k);
        push(3, 8'hD5);
        run(6 * FRAME);
        // R3: fill ch0 to BUF_DEPTH-1 so its pointer wraps
        for (int k = 0; k < DEP - 1; k++) push(0, 8'h30 + 7 * k);
        run(9 * FRAME);
        // R10: clear flags; ch1 stays empty so its flag returns
        clear_flags(4'b1111);
        run(2 * FRAME);
        // R8 reprogrammed idle; R7 mode 11 also pads
        set_cfg(8'h3C, 8'hA5);
        set_assoc(4, 1, 0, 2, 3);
        set_assoc(6, 1, 0, 1, 0);   // second slot on ch1 with tone
        run(3 * FRAME);
        // R10: drop ch3 slot, clear only its flag; stays clear
        set_assoc(5, 0, 1, 3, 0);
        clear_flags(4'b1000);
        run(2 * FRAME);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(100000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule